// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control word and the slot status word of a hot-plug capable downstream or root port. It also decides when software must be told about a hot-plug event. Configuration writes reach it with separate hit flags for the control word and the status word, so one access can touch either word or both. Three side-band requests come from the platform: a hot insertion, an insertion already present at power-up, and a removal request.

Each write to the control word counts as one command. The command completes at once and raises the command-completed event. An interlock control bit flips the interlock status and never reads back as one. A control write that turns the power controller off, with the power indicator set to off, detaches a present device. Events are signalled either as a level interrupt or, when message interrupts are enabled, as a one-cycle pulse carrying a 5-bit vector.

Top module: `hp_slot_ctrl`

## Requirements
- R1: A cycle with `wr_en_i` and `wr_ctl_i` high is one command. On the next clock `ctl_o` takes the write data masked to the writable fields, and status bit 4 (command completed) is set, whatever the write changed. Control layout: bit0 attention-button enable, bit3 presence-change enable, bit4 command-complete enable, bit5 hot-plug interrupt enable, [7:6] attention indicator, [9:8] power indicator, bit10 power controller control (writable only with a power controller), bit11 interlock control. Indicator codes are 01 on, 10 blink and 11 off.
- R2: A control write with bit 11 set inverts status bit 7 (interlock engaged). `ctl_o[11]` always reads 0.
- R3: The pending condition is control bit 5 AND a non-zero value of (status AND control AND mask 0x0019). The mask covers bit0 attention pressed, bit3 presence changed and bit4 command completed.
- R4: When `msi_en_i` is 1 and the pending condition goes from 0 to 1, `msg_pulse_o` is high for exactly one cycle and `msg_vec_o` carries `msg_num_i`. Any value 0 to 31 is valid. Raising an event bit that is already set gives no new pulse.
- R5: `irq_o` equals the registered pending condition while `msi_en_i` is 0, and is 0 while `msi_en_i` is 1.
- R6: A status write clears the bits among 0, 3 and 4 whose write data is 1. Bit 6 (presence detect state), bit 7 and all other bits ignore status writes. If an event is raised in the same cycle as its clear, the event wins.
- R7: A hot insertion sets bit 6 and raises bits 3 and 0. A power-up insertion (`boot_ins_i`) sets only bit 6 and raises no event.
- R8: A removal request raises bit 0. While bit 7 is set, every insertion or removal request leaves the status unchanged and pulses `req_err_o` for one cycle.
- R9: If bit 6 is set and a control write carries bit 10 = 1 with [9:8] = 11, then bit 6 clears and bit 3 is raised on the next clock.
- R10: Reset (synchronous, `rst_n` low) clears all enables, bit 11 and the power indicator, and sets the attention indicator to off. With a power controller, the reset state is: bit 10 = 0 and power indicator on if `populated_i` is 1; otherwise bit 10 = 1 and power indicator off. Status resets to bit 6 = `populated_i`, all other bits 0. `irq_o`, `msg_pulse_o` and `req_err_o` reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| populated_i | input | 1 | Slot occupancy, sampled while in reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_ctl_i | input | 1 | Write touches the control word |
| wr_sts_i | input | 1 | Write touches the status word |
| wr_ctl_data_i | input | 16 | Control word write data |
| wr_sts_data_i | input | 16 | Status word write data (1 clears) |
| ins_req_i | input | 1 | Hot insertion request |
| boot_ins_i | input | 1 | Insertion present at power-up |
| rem_req_i | input | 1 | Removal request |
| msi_en_i | input | 1 | Message interrupts enabled |
| msg_num_i | input | VEC_W | Interrupt message number |
| ctl_o | output | 16 | Slot control word |
| sts_o | output | 16 | Slot status word |
| irq_o | output | 1 | Level interrupt |
| msg_pulse_o | output | 1 | One-cycle message request |
| msg_vec_o | output | VEC_W | Vector of the last message |
| req_err_o | output | 1 | Request refused, interlock engaged |

## Verification
The bench builds the block with HAS_PWR=1 and VEC_W=5. With a power controller present, the power-controller field is writable, so the detach path of R9 can be reached. Both reset variants of R10 are checked: the bench resets once with the slot populated and once with it empty. The 5-bit vector width lets the bench send the top vector 31 as well as a low one.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int SW = 16;
  // status bit positions
  localparam int S_ABP = 0;
  localparam int S_PDC = 3;
  localparam int S_CC  = 4;
  localparam int S_PDS = 6;
  localparam int S_EIS = 7;
  // control bit positions
  localparam int C_HPIE = 5;
  localparam int C_AIL  = 6;
  localparam int C_PIL  = 8;
  localparam int C_PCC  = 10;
  localparam int C_EIC  = 11;
  localparam logic [1:0] IND_ON  = 2'b01;
  localparam logic [1:0] IND_OFF = 2'b11;
  localparam logic [SW-1:0] EV_MASK = 16'h0019;

  function automatic logic [SW-1:0] ctl_wmask(input bit pwr);
    return 16'h03F9 | (pwr ? 16'h0400 : 16'h0000);
  endfunction

  function automatic logic [SW-1:0] ctl_reset(input bit pwr, input logic pop);
    logic [SW-1:0] v;
    v = '0;
    v[C_AIL +: 2] = IND_OFF;
    if (pwr) begin
      v[C_PIL +: 2] = pop ? IND_ON : IND_OFF;
      v[C_PCC]      = ~pop;
    end
    return v;
  endfunction

  function automatic logic pending(input logic [SW-1:0] c, input logic [SW-1:0] s);
    return c[C_HPIE] && ((s & c & EV_MASK) != '0);
  endfunction
endpackage

// File: rtl/hp_slot_ctl_reg.sv
module hp_slot_ctl_reg
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          populated_i,
  input  logic          wr_i,
  input  logic [SW-1:0] data_i,
  output logic [SW-1:0] ctl_q_o,
  output logic [SW-1:0] ctl_d_o,
  output logic          eic_hit_o,
  output logic          cmd_done_o,
  output logic          off_req_o
);
  logic [SW-1:0] ctl_q;
  logic [SW-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_i) ctl_d = data_i & ctl_wmask(HAS_PWR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= ctl_reset(HAS_PWR, populated_i);
    else        ctl_q <= ctl_d;
  end

  assign ctl_q_o    = ctl_q;
  assign ctl_d_o    = ctl_d;
  assign cmd_done_o = wr_i;
  assign eic_hit_o  = wr_i & data_i[C_EIC];
  assign off_req_o  = wr_i & data_i[C_PCC] & (data_i[C_PIL +: 2] == IND_OFF);
endmodule

// File: rtl/hp_slot_sts_reg.sv
module hp_slot_sts_reg
  import hp_slot_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          populated_i,
  input  logic          clr_i,
  input  logic [SW-1:0] clr_data_i,
  input  logic          cmd_done_i,
  input  logic          eic_hit_i,
  input  logic          off_req_i,
  input  logic          ins_i,
  input  logic          boot_i,
  input  logic          rem_i,
  output logic [SW-1:0] sts_q_o,
  output logic [SW-1:0] sts_d_o,
  output logic          err_o
);
  logic [SW-1:0] sts_q, sts_d, set_v, clr_v;
  logic locked, ins_ok, boot_ok, rem_ok, detach, err_q;

  always_comb begin
    locked  = sts_q[S_EIS];
    ins_ok  = ins_i  & ~locked;
    boot_ok = boot_i & ~locked;
    rem_ok  = rem_i  & ~locked;
    detach  = off_req_i & sts_q[S_PDS];
    set_v        = '0;
    set_v[S_CC]  = cmd_done_i;
    set_v[S_PDC] = ins_ok | detach;
    set_v[S_ABP] = ins_ok | rem_ok;
    clr_v = clr_i ? (clr_data_i & EV_MASK) : '0;
    // clear first, then set: a raised event beats its own clear
    sts_d = (sts_q & ~clr_v) | set_v;
    sts_d[S_EIS] = sts_q[S_EIS] ^ eic_hit_i;
    if (ins_ok | boot_ok) sts_d[S_PDS] = 1'b1;
    else if (detach)      sts_d[S_PDS] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= {{(SW-S_PDS-1){1'b0}}, populated_i, {S_PDS{1'b0}}};
      err_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      err_q <= locked & (ins_i | boot_i | rem_i);
    end
  end

  assign sts_q_o = sts_q;
  assign sts_d_o = sts_d;
  assign err_o   = err_q;
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    ctl_d_i,
  input  logic [SW-1:0]    sts_d_i,
  input  logic             msi_en_i,
  input  logic [VEC_W-1:0] msg_num_i,
  output logic             pend_q_o,
  output logic             irq_o,
  output logic             pulse_o,
  output logic [VEC_W-1:0] vec_o
);
  logic pend_d, pend_q, pulse_d, pulse_q;
  logic [VEC_W-1:0] vec_q;

  assign pend_d  = pending(ctl_d_i, sts_d_i);
  assign pulse_d = msi_en_i & pend_d & ~pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
      if (pulse_d) vec_q <= msg_num_i;
    end
  end

  assign pend_q_o = pend_q;
  assign irq_o    = pend_q & ~msi_en_i;
  assign pulse_o  = pulse_q;
  assign vec_o    = vec_q;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR = 1'b1,
  parameter int VEC_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             populated_i,
  input  logic             wr_en_i,
  input  logic             wr_ctl_i,
  input  logic             wr_sts_i,
  input  logic [15:0]      wr_ctl_data_i,
  input  logic [15:0]      wr_sts_data_i,
  input  logic             ins_req_i,
  input  logic             boot_ins_i,
  input  logic             rem_req_i,
  input  logic             msi_en_i,
  input  logic [VEC_W-1:0] msg_num_i,
  output logic [15:0]      ctl_o,
  output logic [15:0]      sts_o,
  output logic             irq_o,
  output logic             msg_pulse_o,
  output logic [VEC_W-1:0] msg_vec_o,
  output logic             req_err_o
);
  logic          ctl_wr, sts_wr, eic_hit, cmd_done, off_req, pend_q;
  logic [SW-1:0] ctl_d, sts_d;

  assign ctl_wr = wr_en_i & wr_ctl_i;
  assign sts_wr = wr_en_i & wr_sts_i;

  hp_slot_ctl_reg #(.HAS_PWR(HAS_PWR)) u_ctl (
    .clk(clk), .rst_n(rst_n), .populated_i(populated_i),
    .wr_i(ctl_wr), .data_i(wr_ctl_data_i),
    .ctl_q_o(ctl_o), .ctl_d_o(ctl_d),
    .eic_hit_o(eic_hit), .cmd_done_o(cmd_done), .off_req_o(off_req)
  );

  hp_slot_sts_reg u_sts (
    .clk(clk), .rst_n(rst_n), .populated_i(populated_i),
    .clr_i(sts_wr), .clr_data_i(wr_sts_data_i),
    .cmd_done_i(cmd_done), .eic_hit_i(eic_hit), .off_req_i(off_req),
    .ins_i(ins_req_i), .boot_i(boot_ins_i), .rem_i(rem_req_i),
    .sts_q_o(sts_o), .sts_d_o(sts_d), .err_o(req_err_o)
  );

  hp_slot_notify #(.VEC_W(VEC_W)) u_ntf (
    .clk(clk), .rst_n(rst_n),
    .ctl_d_i(ctl_d), .sts_d_i(sts_d),
    .msi_en_i(msi_en_i), .msg_num_i(msg_num_i),
    .pend_q_o(pend_q), .irq_o(irq_o), .pulse_o(msg_pulse_o), .vec_o(msg_vec_o)
  );
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en_i,
  input logic        wr_ctl_i,
  input logic        wr_sts_i,
  input logic [15:0] wr_ctl_data_i,
  input logic [15:0] wr_sts_data_i,
  input logic        ins_req_i,
  input logic        boot_ins_i,
  input logic        rem_req_i,
  input logic        msi_en_i,
  input logic [15:0] ctl_o,
  input logic [15:0] sts_o,
  input logic        irq_o,
  input logic        msg_pulse_o,
  input logic        req_err_o,
  input logic        pend_q
);
  assert_cmd_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_ctl_i) |=> sts_o[4]);

  assert_eic_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_ctl_i && wr_ctl_data_i[11]) |=> (sts_o[7] != $past(sts_o[7])) && !ctl_o[11]);

  assert_irq_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en_i |-> (irq_o == (ctl_o[5] && ((sts_o & ctl_o & 16'h0019) != 16'h0))));

  assert_pulse_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse_o |-> (pend_q && !$past(pend_q)));

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en_i |-> !irq_o);

  assert_w1c_abp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sts_i && wr_sts_data_i[0] && !ins_req_i && !rem_req_i) |=> !sts_o[0]);

  assert_hot_insert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req_i && !sts_o[7]) |=> (sts_o[6] && sts_o[3] && sts_o[0]));

  assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ins_req_i || boot_ins_i || rem_req_i) && sts_o[7]) |=> req_err_o);
endmodule

bind hp_slot_ctrl hp_slot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_ctl_i(wr_ctl_i), .wr_sts_i(wr_sts_i),
  .wr_ctl_data_i(wr_ctl_data_i), .wr_sts_data_i(wr_sts_data_i),
  .ins_req_i(ins_req_i), .boot_ins_i(boot_ins_i), .rem_req_i(rem_req_i),
  .msi_en_i(msi_en_i), .ctl_o(ctl_o), .sts_o(sts_o), .irq_o(irq_o),
  .msg_pulse_o(msg_pulse_o), .req_err_o(req_err_o), .pend_q(pend_q)
);

// File: tb/hp_slot_ctrl_tb_top.sv
module hp_slot_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        populated_i = 1'b1;
  logic        wr_en_i = 1'b0, wr_ctl_i = 1'b0, wr_sts_i = 1'b0;
  logic [15:0] wr_ctl_data_i = '0, wr_sts_data_i = '0;
  logic        ins_req_i = 1'b0, boot_ins_i = 1'b0, rem_req_i = 1'b0, msi_en_i = 1'b0;
  logic [4:0]  msg_num_i = '0;
  logic [15:0] ctl_o, sts_o;
  logic        irq_o, msg_pulse_o, req_err_o;
  logic [4:0]  msg_vec_o;

  always #10ns clk = ~clk;

  hp_slot_ctrl #(.HAS_PWR(1'b1), .VEC_W(5)) dut_i (.*);

  typedef struct {
    logic [15:0] ctl, sts;
    logic        irq, pulse, err;
    logic [4:0]  vec;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0;
  logic [15:0] m_ctl, m_sts;
  logic        m_pend;
  logic [4:0]  m_vec;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: drive one cycle of stimulus and push the predicted result
  task automatic step(input bit rst, input bit pop, input bit wr, input bit ch, input bit sh,
                      input logic [15:0] cd, input logic [15:0] sd,
                      input bit ins, input bit boot, input bit rem,
                      input bit msi, input logic [4:0] vec, input string tag);
    exp_t e;
    logic [15:0] cn, sn;
    logic lock, pn, pulse;
    @(negedge clk);
    rst_n = ~rst; populated_i = pop; wr_en_i = wr; wr_ctl_i = ch; wr_sts_i = sh;
    wr_ctl_data_i = cd; wr_sts_data_i = sd; ins_req_i = ins; boot_ins_i = boot;
    rem_req_i = rem; msi_en_i = msi; msg_num_i = vec;
    if (rst) begin
      m_ctl = pop ? 16'h01C0 : 16'h07C0;
      m_sts = pop ? 16'h0040 : 16'h0000;
      m_pend = 1'b0; m_vec = '0;
      e = '{m_ctl, m_sts, 1'b0, 1'b0, 1'b0, m_vec, tag};
    end else begin
      cn = m_ctl; sn = m_sts; lock = m_sts[7];
      if (wr && sh) sn = sn & ~(sd & 16'h0019);
      if (wr && ch) begin
        cn = cd & 16'h07F9;
        if (cd[11]) sn[7] = ~sn[7];
        if (m_sts[6] && cd[10] && cd[9:8] == 2'b11) begin sn[6] = 1'b0; sn[3] = 1'b1; end
        sn[4] = 1'b1;
      end
      if (!lock) begin
        if (ins)  begin sn[6] = 1'b1; sn[3] = 1'b1; sn[0] = 1'b1; end
        if (boot) sn[6] = 1'b1;
        if (rem)  sn[0] = 1'b1;
      end
      pn = cn[5] && ((sn & cn & 16'h0019) != 16'h0);
      pulse = msi && pn && !m_pend;
      if (pulse) m_vec = vec;
      e = '{cn, sn, pn && !msi, pulse, lock && (ins || boot || rem), m_vec, tag};
      m_ctl = cn; m_sts = sn; m_pend = pn;
    end
    exp_q.push_back(e);
  endtask

  task automatic idle(input bit msi, input string tag);
    step(0, populated_i, 0, 0, 0, 16'h0, 16'h0, 0, 0, 0, msi, 5'd0, tag);
  endtask

  // monitor: compare one result per clock, a quarter period after the edge
  initial forever begin
    exp_t e;
    @(posedge clk);
    #5ns;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(ctl_o == e.ctl, e.tag, "ctl", ctl_o, e.ctl);
      chk(sts_o == e.sts, e.tag, "sts", sts_o, e.sts);
      chk(irq_o == e.irq, e.tag, "irq", {15'd0, irq_o}, {15'd0, e.irq});
      chk(msg_pulse_o == e.pulse, e.tag, "pulse", {15'd0, msg_pulse_o}, {15'd0, e.pulse});
      chk(req_err_o == e.err, e.tag, "err", {15'd0, req_err_o}, {15'd0, e.err});
      if (e.pulse) chk(msg_vec_o == e.vec, e.tag, "vec", {11'd0, msg_vec_o}, {11'd0, e.vec});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 reset populated");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 reset populated");
    idle(0, "R10 idle after reset");
    // R1 R3 R5: enable events, command completes, level irq rises
    step(0, 1, 1, 1, 0, 16'h01F9, 0, 0, 0, 0, 0, 0, "R1 R3 R5 first command");
    step(0, 1, 1, 0, 1, 0, 16'h0010, 0, 0, 0, 0, 0, "R6 clear cc, R5 irq drops");
    step(0, 1, 0, 1, 0, 16'h01F9, 0, 0, 0, 0, 0, 0, "R1 no strobe, no command");
    // R4 message pulse with low vector
    step(0, 1, 1, 1, 0, 16'h01F9, 0, 0, 0, 0, 1, 5'd5, "R4 pulse vec 5");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 5'd6, "R8 removal, R4 no second pulse");
    step(0, 1, 1, 0, 1, 0, 16'hFFFF, 0, 0, 0, 1, 0, "R6 w1c keeps read-only bits");
    // R2 interlock toggle with top vector
    step(0, 1, 1, 1, 0, 16'h09F9, 0, 0, 0, 0, 1, 5'd31, "R2 R4 interlock on vec 31");
    step(0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, "R8 insertion refused");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, "R8 removal refused");
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R8 boot insertion refused");
    step(0, 1, 1, 1, 0, 16'h09F9, 0, 0, 0, 0, 1, 5'd3, "R2 interlock off");
    step(0, 1, 1, 0, 1, 0, 16'h0019, 0, 0, 0, 0, 0, "R6 clear all, R5 level mode");
    step(0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 hot insertion");
    step(0, 1, 1, 1, 1, 16'h01F9, 16'h0010, 0, 0, 0, 0, 0, "R6 set beats clear");
    step(0, 1, 1, 1, 0, 16'h07F9, 0, 0, 0, 0, 0, 0, "R9 power off detach");
    step(0, 1, 1, 1, 0, 16'h07F9, 0, 0, 0, 0, 0, 0, "R9 no detach when empty");
    step(0, 1, 1, 0, 1, 0, 16'h0019, 0, 0, 0, 0, 0, "R6 clear events");
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R7 boot insertion no event");
    step(0, 1, 1, 1, 0, 16'h01D9, 0, 0, 0, 0, 0, 0, "R3 no hpie, no irq");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 reset empty");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 reset empty");
    idle(0, "R10 idle empty");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule